// File: doc/BRIEF.md
# Interrupt Pending-Clear Register Bank

This block holds the life-cycle state of a configurable set of interrupt lines and lets software remove the pending condition through a bank of 32-bit write-one-to-clear registers. Each line has its own four-state machine, with the states IDLE (inactive), PEND (pending), ACT (active) and ACTPEND (active and pending). Each line also has a software-set latch. Hardware requests come from per-line inputs that are either edge-triggered or level-sensitive. A consumer moves lines from pending to active with an acknowledge strobe and back out with a completion strobe.

A clear write does not always clear the bit it names. Lines 0..15 are software-generated and their bits only reflect state. Unimplemented line numbers read as zero. A line owned by the secure world is hidden from a non-secure access unless that line grants permission. A level-sensitive line whose input is still high stays pending after a clear. A companion set window raises the software latch, so a level line can also be pending while its input is low.

State transitions, evaluated on each clock edge. Here a fresh request means a rising input edge in edge mode, a high input in level mode, or a set write. The hold condition is always true for an edge line and equals latch-or-input for a level line.
- IDLE->PEND on a fresh request.
- PEND->ACT on acknowledge, or PEND->ACTPEND if a fresh request comes in the same cycle. PEND->IDLE when a clear write arrives with no fresh request, or when hold is lost.
- ACT->ACTPEND on a fresh request. ACT->IDLE on completion, or ACT->PEND if a fresh request comes in the same cycle.
- ACTPEND->ACT on a clear write with no fresh request, or when hold is lost. ACTPEND->PEND on completion.

Top module: `irq_pend_clear_bank`

## Requirements
- R1: The bank has LINE_COUNT+1 registers. Clear register n is at byte address 0x280+4n and set register n is at 0x200+4n. Bit x of register n belongs to line 32n+x. Any other address, including unaligned ones, reads 0 and ignores writes.
- R2: A read from either window returns 1 for a line in PEND or ACTPEND and 0 for a line in IDLE or ACT. The irq_pending output is 1 in PEND and ACTPEND. The irq_active output is 1 in ACT and ACTPEND.
- R3: Writing 1 to a clear bit moves PEND to IDLE and ACTPEND to ACT. Writing 0 has no effect. Writing 1 for a line in IDLE or ACT has no effect.
- R4: Lines 0..15 ignore both clear and set writes. Their bits still read back the pending state, which they take from input edges.
- R5: A level line whose input is high stays pending after a clear write. Once its input goes low and its latch is clear, it leaves the pending state on the next edge.
- R6: An edge line becomes pending on a rising input. A clear write in the same cycle as a new rising edge leaves the line pending.
- R7: Line numbers at or above NUM_IRQ read as 0 and ignore writes.
- R8: irq_grp_sec=1 marks a secure-owned line. On an access with bus_nonsec=1, a secure-owned line reads 0 and ignores writes unless its irq_ns_ok bit is 1.
- R9: Acknowledge with ack_id=i moves line i from PEND to ACT, or to ACTPEND when a fresh request comes in the same cycle. In any other state it has no effect.
- R10: Completion with done_id=i moves ACT to IDLE (or to PEND on a fresh request) and ACTPEND to PEND.
- R11: Reset puts every line in IDLE with its latch clear.
- R12: A set write of 1 makes a line pending. A level line stays pending through its latch while its input is low, until a clear or acknowledge removes the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address, used for both read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_nonsec | input | 1 | 1 marks a non-secure access |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_in | input | NUM_IRQ | Per-line request inputs |
| irq_level | input | NUM_IRQ | 1 selects level-sensitive, 0 selects edge-triggered |
| irq_grp_sec | input | NUM_IRQ | 1 marks a secure-owned line |
| irq_ns_ok | input | NUM_IRQ | 1 grants non-secure access to a secure-owned line |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | ID_W | Line being acknowledged |
| done_valid | input | 1 | Completion strobe |
| done_id | input | ID_W | Line being completed |
| irq_pending | output | NUM_IRQ | Per-line pending flag (PEND or ACTPEND) |
| irq_active | output | NUM_IRQ | Per-line active flag (ACT or ACTPEND) |

## Verification
The hardest case to reach is a clear write that coincides with a new rising edge on a line that is already pending. Reaching it needs a prior pulse and then the input step and the bus write placed at the same clock edge. The bench drives both at one falling edge. ACTPEND is also awkward to reach: it needs an acknowledge followed by a second request before completion. The directed sequences reach it through both an edge pulse and a level input that is held high across the acknowledge.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_PEND    = 2'b01,
        ST_ACT     = 2'b10,
        ST_ACTPEND = 2'b11
    } irq_state_e;

    localparam int unsigned CLR_BASE  = 'h280;
    localparam int unsigned SET_BASE  = 'h200;
    localparam int unsigned SGI_COUNT = 16;
    localparam int unsigned REG_BITS  = 32;
endpackage

// File: rtl/irq_pend_cell.sv
module irq_pend_cell
    import irq_pend_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_in,
    input  logic is_level,
    input  logic set_req,
    input  logic clr_req,
    input  logic ack_req,
    input  logic done_req,
    output logic st_pending,
    output logic st_active
);
    irq_state_e state_q, state_d;
    logic in_q, latch_q, latch_d;
    logic rise, fresh, hold, keep;

    assign rise  = irq_in & ~in_q;
    assign fresh = (is_level ? irq_in : rise) | set_req;
    assign hold  = is_level ? (latch_q | irq_in) : 1'b1;
    assign keep  = clr_req ? fresh : (hold | fresh);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = fresh ? ST_PEND : ST_IDLE;
            ST_PEND: begin
                if (ack_req) state_d = fresh ? ST_ACTPEND : ST_ACT;
                else         state_d = keep  ? ST_PEND    : ST_IDLE;
            end
            ST_ACT: begin
                if (done_req) state_d = fresh ? ST_PEND    : ST_IDLE;
                else          state_d = fresh ? ST_ACTPEND : ST_ACT;
            end
            ST_ACTPEND: begin
                if (done_req) state_d = keep ? ST_PEND    : ST_IDLE;
                else          state_d = keep ? ST_ACTPEND : ST_ACT;
            end
        endcase
    end

    assign latch_d = set_req |
                     (latch_q & ~clr_req & ~(ack_req & (state_q == ST_PEND)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            latch_q <= 1'b0;
            in_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            latch_q <= latch_d;
            in_q    <= irq_in;
        end
    end

    always_comb begin
        st_pending = 1'b0;
        st_active  = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_PEND:    st_pending = 1'b1;
            ST_ACT:     st_active  = 1'b1;
            ST_ACTPEND: begin
                st_pending = 1'b1;
                st_active  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/irq_pend_decode.sv
module irq_pend_decode
    import irq_pend_pkg::*;
#(
    parameter int NUM_REGS = 2,
    parameter int NUM_IRQ  = 48,
    parameter int ADDR_W   = 12
) (
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_nonsec,
    input  logic [NUM_IRQ-1:0]  grp_sec,
    input  logic [NUM_IRQ-1:0]  ns_ok,
    input  logic [NUM_IRQ-1:0]  pend_state,
    output logic [NUM_IRQ-1:0]  set_strobe,
    output logic [NUM_IRQ-1:0]  clr_strobe,
    output logic [31:0]         rdata
);
    localparam int SLOTS     = NUM_REGS * REG_BITS;
    localparam int WIN_BYTES = NUM_REGS * 4;

    logic              aligned, in_clr, in_set;
    logic [ADDR_W-1:0] clr_word, set_word, word_sel;
    logic [NUM_IRQ-1:0] vis;
    logic [SLOTS-1:0]   vis_pad;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign in_clr   = aligned && (bus_addr >= ADDR_W'(CLR_BASE)) &&
                      (bus_addr < ADDR_W'(CLR_BASE + WIN_BYTES));
    assign in_set   = aligned && (bus_addr >= ADDR_W'(SET_BASE)) &&
                      (bus_addr < ADDR_W'(SET_BASE + WIN_BYTES));
    assign clr_word = (bus_addr - ADDR_W'(CLR_BASE)) >> 2;
    assign set_word = (bus_addr - ADDR_W'(SET_BASE)) >> 2;
    assign word_sel = in_clr ? clr_word : set_word;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        logic access_ok, bit_hit;
        assign access_ok = ~bus_nonsec | ~grp_sec[i] | ns_ok[i];
        assign bit_hit   = bus_wr && (word_sel == ADDR_W'(i / REG_BITS)) &&
                           bus_wdata[i % REG_BITS] && access_ok;
        assign vis[i]    = pend_state[i] & access_ok;
        if (i < SGI_COUNT) begin : g_sgi
            assign clr_strobe[i] = 1'b0;
            assign set_strobe[i] = 1'b0;
        end else begin : g_periph
            assign clr_strobe[i] = bit_hit & in_clr;
            assign set_strobe[i] = bit_hit & in_set;
        end
    end

    assign vis_pad = SLOTS'(vis);

    always_comb begin
        rdata = '0;
        if (in_clr || in_set) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (word_sel == ADDR_W'(r)) rdata = vis_pad[r*REG_BITS +: REG_BITS];
            end
        end
    end
endmodule

// File: rtl/irq_pend_clear_bank.sv
module irq_pend_clear_bank
    import irq_pend_pkg::*;
#(
    parameter int LINE_COUNT = 1,
    parameter int NUM_IRQ    = 48,
    parameter int ADDR_W     = 12,
    localparam int NUM_REGS  = LINE_COUNT + 1,
    localparam int ID_W      = $clog2(NUM_REGS * REG_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_nonsec,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_IRQ-1:0]  irq_in,
    input  logic [NUM_IRQ-1:0]  irq_level,
    input  logic [NUM_IRQ-1:0]  irq_grp_sec,
    input  logic [NUM_IRQ-1:0]  irq_ns_ok,
    input  logic                ack_valid,
    input  logic [ID_W-1:0]     ack_id,
    input  logic                done_valid,
    input  logic [ID_W-1:0]     done_id,
    output logic [NUM_IRQ-1:0]  irq_pending,
    output logic [NUM_IRQ-1:0]  irq_active
);
    logic [NUM_IRQ-1:0] set_strobe, clr_strobe;

    irq_pend_decode #(
        .NUM_REGS (NUM_REGS),
        .NUM_IRQ  (NUM_IRQ),
        .ADDR_W   (ADDR_W)
    ) u_decode (
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_nonsec (bus_nonsec),
        .grp_sec    (irq_grp_sec),
        .ns_ok      (irq_ns_ok),
        .pend_state (irq_pending),
        .set_strobe (set_strobe),
        .clr_strobe (clr_strobe),
        .rdata      (bus_rdata)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cell
        irq_pend_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .irq_in     (irq_in[i]),
            .is_level   (irq_level[i]),
            .set_req    (set_strobe[i]),
            .clr_req    (clr_strobe[i]),
            .ack_req    (ack_valid && (ack_id == ID_W'(i))),
            .done_req   (done_valid && (done_id == ID_W'(i))),
            .st_pending (irq_pending[i]),
            .st_active  (irq_active[i])
        );
    end
endmodule

// File: rtl/irq_pend_clear_bank_chk.sv
module irq_pend_clear_bank_chk
    import irq_pend_pkg::*;
#(
    parameter int LINE_COUNT = 1,
    parameter int NUM_IRQ    = 48,
    parameter int ADDR_W     = 12,
    localparam int NUM_REGS  = LINE_COUNT + 1,
    localparam int ID_W      = $clog2(NUM_REGS * REG_BITS),
    localparam int REM       = NUM_IRQ % REG_BITS
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [31:0]         bus_wdata,
    input logic                bus_nonsec,
    input logic [31:0]         bus_rdata,
    input logic [NUM_IRQ-1:0]  irq_in,
    input logic [NUM_IRQ-1:0]  irq_level,
    input logic [NUM_IRQ-1:0]  irq_grp_sec,
    input logic [NUM_IRQ-1:0]  irq_ns_ok,
    input logic                ack_valid,
    input logic [ID_W-1:0]     ack_id,
    input logic                done_valid,
    input logic [ID_W-1:0]     done_id,
    input logic [NUM_IRQ-1:0]  irq_pending,
    input logic [NUM_IRQ-1:0]  irq_active
);
    // R11: first edge after reset release sees every line idle
    a_r11_reset_idle: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (irq_pending == '0 && irq_active == '0));

    if (REM != 0) begin : g_unimpl
        // R7: unimplemented bits of the last clear register read zero
        a_r7_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr == ADDR_W'(CLR_BASE + 4 * (NUM_REGS - 1))) |->
            ((bus_rdata >> REM) == 32'd0));
    end

    for (genvar k = 0; k < SGI_COUNT; k++) begin : g_sgi
        // R4: a clear write never removes a software-generated line's pending state
        a_r4_sgi_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(CLR_BASE) && bus_wdata[k] &&
             irq_pending[k] && !(ack_valid && ack_id == ID_W'(k)))
            |=> irq_pending[k]);
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        // R9: acknowledging a pending, inactive line activates it
        a_r9_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_valid && ack_id == ID_W'(i) && irq_pending[i] && !irq_active[i])
            |=> irq_active[i]);
        // R10: completion always leaves the active state
        a_r10_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
            (done_valid && done_id == ID_W'(i) && irq_active[i])
            |=> !irq_active[i]);
        // R5: a high level input keeps the line pending
        a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_level[i] && irq_in[i]) |=> irq_pending[i]);
        // R8: secure-owned line hidden from non-secure reads without permission
        a_r8_ns_hidden: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_nonsec && irq_grp_sec[i] && !irq_ns_ok[i] &&
             bus_addr == ADDR_W'(CLR_BASE + 4 * (i / REG_BITS)))
            |-> !bus_rdata[i % REG_BITS]);
    end
endmodule

bind irq_pend_clear_bank irq_pend_clear_bank_chk #(
    .LINE_COUNT (LINE_COUNT),
    .NUM_IRQ    (NUM_IRQ),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_nonsec  (bus_nonsec),
    .bus_rdata   (bus_rdata),
    .irq_in      (irq_in),
    .irq_level   (irq_level),
    .irq_grp_sec (irq_grp_sec),
    .irq_ns_ok   (irq_ns_ok),
    .ack_valid   (ack_valid),
    .ack_id      (ack_id),
    .done_valid  (done_valid),
    .done_id     (done_id),
    .irq_pending (irq_pending),
    .irq_active  (irq_active)
);

// File: tb/irq_pend_clear_bank_test.sv
module irq_pend_clear_bank_test;
    localparam int NIRQ = 48;
    localparam int IDW  = 6;
    localparam int NV   = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic            bus_nonsec = 1'b0;
    logic [31:0]     bus_rdata;
    logic [NIRQ-1:0] irq_in = '0;
    logic [NIRQ-1:0] irq_level   = 48'hFF00_0000_0000;
    logic [NIRQ-1:0] irq_grp_sec = 48'h000F_0000_0000;
    logic [NIRQ-1:0] irq_ns_ok   = 48'h0004_0000_0000;
    logic            ack_valid = 1'b0;
    logic [IDW-1:0]  ack_id = '0;
    logic            done_valid = 1'b0;
    logic [IDW-1:0]  done_id = '0;
    logic [NIRQ-1:0] irq_pending, irq_active;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    irq_pend_clear_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_nonsec(bus_nonsec), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_level(irq_level), .irq_grp_sec(irq_grp_sec),
        .irq_ns_ok(irq_ns_ok), .ack_valid(ack_valid), .ack_id(ack_id),
        .done_valid(done_valid), .done_id(done_id),
        .irq_pending(irq_pending), .irq_active(irq_active)
    );

    // {kind: 0 read-check, 1 clear write, 2 set write; nonsec; addr; data/expected}
    localparam logic [46:0] VEC [NV] = '{
        {2'd2, 1'b0, 12'h204, 32'h0000_FFFF},
        {2'd0, 1'b0, 12'h284, 32'h0000_FFFF},
        {2'd0, 1'b0, 12'h204, 32'h0000_FFFF},
        {2'd0, 1'b1, 12'h284, 32'h0000_FFF4},
        {2'd1, 1'b1, 12'h284, 32'h0000_000F},
        {2'd0, 1'b0, 12'h284, 32'h0000_FFFB},
        {2'd1, 1'b0, 12'h284, 32'h0000_0000},
        {2'd0, 1'b0, 12'h284, 32'h0000_FFFB},
        {2'd1, 1'b0, 12'h284, 32'hFFFF_0000},
        {2'd0, 1'b0, 12'h284, 32'h0000_FFFB},
        {2'd1, 1'b0, 12'h284, 32'h0000_0F00},
        {2'd0, 1'b0, 12'h284, 32'h0000_F0FB},
        {2'd0, 1'b0, 12'h288, 32'h0000_0000},
        {2'd2, 1'b0, 12'h200, 32'hFFFF_FFFF},
        {2'd0, 1'b0, 12'h280, 32'hFFFF_0000},
        {2'd1, 1'b0, 12'h280, 32'hFFFF_FFFF},
        {2'd0, 1'b0, 12'h280, 32'h0000_0000},
        {2'd2, 1'b0, 12'h288, 32'hFFFF_FFFF},
        {2'd0, 1'b0, 12'h284, 32'h0000_F0FB},
        {2'd0, 1'b0, 12'h300, 32'h0000_0000}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input bit ns);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_nonsec = ns; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_nonsec = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input bit ns, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_nonsec = ns;
        #1 d = bus_rdata;
        bus_nonsec = 1'b0;
    endtask

    task automatic pulse(input int i);
        @(negedge clk); irq_in[i] = 1'b1;
        @(negedge clk); irq_in[i] = 1'b0;
    endtask

    task automatic ack(input int i);
        @(negedge clk); ack_valid = 1'b1; ack_id = IDW'(i);
        @(negedge clk); ack_valid = 1'b0;
    endtask

    task automatic done(input int i);
        @(negedge clk); done_valid = 1'b1; done_id = IDW'(i);
        @(negedge clk); done_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        do_reset();
        // R11: reset state
        bus_read(12'h280, 1'b0, rd);
        check(rd == 0, "R11 reset word0", 64'(rd), 0);
        bus_read(12'h284, 1'b0, rd);
        check(rd == 0 && irq_pending == 0 && irq_active == 0, "R11 reset word1",
              64'(rd), 0);

        // R1 R2 R3 R4 R7 R8 R12: table walk
        for (int v = 0; v < NV; v++) begin
            logic [1:0]  kind;
            logic        ns;
            logic [11:0] a;
            logic [31:0] d;
            {kind, ns, a, d} = VEC[v];
            if (kind == 2'd0) begin
                bus_read(a, ns, rd);
                check(rd == d, $sformatf("R1 R2 R3 R8 table entry %0d", v), 64'(rd), 64'(d));
            end else begin
                bus_write(a, d, ns);
            end
        end

        do_reset();
        check(irq_pending == 0, "R11 reset after table", 64'(irq_pending), 0);

        // R6: edge sets pending; clear without new edge drops it
        @(negedge clk); irq_in[20] = 1'b1;
        @(negedge clk);
        check(irq_pending[20] == 1, "R6 rising edge", 64'(irq_pending[20]), 1);
        bus_write(12'h280, 32'h0010_0000, 1'b0);
        check(irq_pending[20] == 0, "R3 clear edge line", 64'(irq_pending[20]), 0);
        @(negedge clk); irq_in[20] = 1'b0;
        pulse(20);
        check(irq_pending[20] == 1, "R6 re-pend", 64'(irq_pending[20]), 1);
        // R6: clear and new edge in the same cycle
        @(negedge clk);
        irq_in[20] = 1'b1; bus_addr = 12'h280; bus_wdata = 32'h0010_0000; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        check(irq_pending[20] == 1, "R6 edge wins over clear", 64'(irq_pending[20]), 1);
        bus_write(12'h280, 32'h0010_0000, 1'b0);
        check(irq_pending[20] == 0, "R3 clear after collision", 64'(irq_pending[20]), 0);
        @(negedge clk); irq_in[20] = 1'b0;

        // R4: software-generated line pends from edge, clear ignored
        pulse(5);
        bus_write(12'h280, 32'h0000_0020, 1'b0);
        bus_read(12'h280, 1'b0, rd);
        check(rd[5] == 1, "R4 sgi clear ignored", 64'(rd[5]), 1);

        // R5: level line held by input across a clear
        @(negedge clk); irq_in[44] = 1'b1;
        bus_write(12'h284, 32'h0000_1000, 1'b0);
        check(irq_pending[44] == 1, "R5 level held", 64'(irq_pending[44]), 1);
        @(negedge clk); irq_in[44] = 1'b0;
        @(negedge clk);
        check(irq_pending[44] == 0, "R5 level drop", 64'(irq_pending[44]), 0);

        // R12: latch keeps a level line pending with input low
        bus_write(12'h204, 32'h0000_1000, 1'b0);
        repeat (3) @(negedge clk);
        check(irq_pending[44] == 1, "R12 latch holds", 64'(irq_pending[44]), 1);
        bus_write(12'h284, 32'h0000_1000, 1'b0);
        check(irq_pending[44] == 0, "R12 latch cleared", 64'(irq_pending[44]), 0);

        // R9 R10 R3: edge line through active states
        pulse(25);
        ack(25);
        check(irq_active[25] == 1 && irq_pending[25] == 0, "R9 ack to active",
              64'({irq_active[25], irq_pending[25]}), 64'b10);
        pulse(25);
        check(irq_active[25] == 1 && irq_pending[25] == 1, "R2 active and pending",
              64'({irq_active[25], irq_pending[25]}), 64'b11);
        bus_write(12'h280, 32'h0200_0000, 1'b0);
        check(irq_active[25] == 1 && irq_pending[25] == 0, "R3 actpend to act",
              64'({irq_active[25], irq_pending[25]}), 64'b10);
        bus_write(12'h280, 32'h0200_0000, 1'b0);
        check(irq_active[25] == 1 && irq_pending[25] == 0, "R3 clear on act no effect",
              64'({irq_active[25], irq_pending[25]}), 64'b10);
        pulse(25);
        done(25);
        check(irq_active[25] == 0 && irq_pending[25] == 1, "R10 actpend to pend",
              64'({irq_active[25], irq_pending[25]}), 64'b01);
        ack(25);
        done(25);
        check(irq_active[25] == 0 && irq_pending[25] == 0, "R10 act to idle",
              64'({irq_active[25], irq_pending[25]}), 64'b00);
        ack(26);
        check(irq_active[26] == 0, "R9 ack on idle ignored", 64'(irq_active[26]), 0);

        // R9 R10: level line acknowledged while input high
        @(negedge clk); irq_in[45] = 1'b1;
        ack(45);
        check(irq_active[45] == 1 && irq_pending[45] == 1, "R9 level ack to actpend",
              64'({irq_active[45], irq_pending[45]}), 64'b11);
        done(45);
        check(irq_active[45] == 0 && irq_pending[45] == 1, "R10 level done to pend",
              64'({irq_active[45], irq_pending[45]}), 64'b01);
        @(negedge clk); irq_in[45] = 1'b0;
        @(negedge clk);
        check(irq_pending[45] == 0, "R5 level release", 64'(irq_pending[45]), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule